// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash model. It watches host bus writes, each made of an address, a data byte and a strobe. It recognises multi-cycle unlock and command sequences, and it launches an internal program or whole-array erase on a small register-file array. The host reads the array through a combinational read port and polls a busy flag and a mode code, which reports whether the device is reading, erasing or programming.

A separate bypass sub-mode lets a host that programs many locations skip the unlock cycles. Two writes then program one location. While in bypass, the decoder accepts only the program code and a two-write exit sequence. It drops every other write.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 00 (read array), `busy` and `bypass` are low, and every array location reads FFh.
- R2: The unlock pair is AAh written at address 555h, then 55h at 2AAh. If it is followed by A0h at 555h, the next write programs the location that the low `IDX_W` address bits select. The new content is old AND data, so programming only clears bits. `busy` is high with `mode` = 10 for exactly `PROG_CYC` cycles, starting in the cycle after that write.
- R3: Chip erase is six writes: the unlock pair, 80h at 555h, the unlock pair again, then 10h at 555h. `busy` is high with `mode` = 01 for 2·`DEPTH` cycles. During the first half every location is cleared to 00h, and during the second half it is set to FFh. Afterwards every location reads FFh.
- R4: The unlock pair followed by 20h at 555h enters bypass mode, and `bypass` goes high in the cycle after that write.
- R5: In bypass, A0h at any address followed by one address/data write programs that location, as in R2, with no unlock cycles. The decoder stays in bypass afterwards.
- R6: In bypass, any write whose data is neither A0h nor 90h is ignored: `bypass` stays high and the array is unchanged. This includes F0h and the unlock codes.
- R7: In bypass, 90h followed by 00h, at any addresses, leaves bypass and returns to read array. If the write after 90h carries other data, the decoder stays in bypass.
- R8: Outside bypass, any write that does not match the next expected cycle of a sequence returns the decoder to read array, and no operation starts.
- R9: Outside bypass, a write of F0h at any point of a sequence resets the decoder to read array. This includes the write that would otherwise carry program data.
- R10: While `busy` is high, every host write is ignored, both by the decoder and by the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | IDX_W | Array read index |
| rd_data | output | 8 | Array content at `rd_addr` (combinational) |
| busy | output | 1 | High while program or erase runs |
| mode | output | 2 | 00 read array, 01 erasing, 10 programming |
| bypass | output | 1 | High while in bypass mode |

## Verification
The assertions check on every cycle that accepted program and erase commands raise `busy` with the matching mode code. They also check that the decoder state is frozen while busy, that stray writes leave the bypass state untouched, that 90h then 00h always exits bypass, and that an erase that finishes leaves the whole array at FFh. Only the bench scenarios can show the cycle grammar end to end. This covers a sequence broken by a wrong address, F0h aborting a pending program, a full unlock sequence issued during a busy program, and the exact length of each busy window. The bench checks these against a behavioural model, with the array read back every idle cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;
    localparam logic [7:0]  UNLOCK_D1     = 8'hAA;
    localparam logic [7:0]  UNLOCK_D2     = 8'h55;
    localparam logic [7:0]  CODE_PROG     = 8'hA0;
    localparam logic [7:0]  CODE_SETUP    = 8'h80;
    localparam logic [7:0]  CODE_ERASE    = 8'h10;
    localparam logic [7:0]  CODE_BYPASS   = 8'h20;
    localparam logic [7:0]  CODE_RESET    = 8'hF0;
    localparam logic [7:0]  CODE_BEXIT1   = 8'h90;
    localparam logic [7:0]  CODE_BEXIT2   = 8'h00;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ERASE = 2'd1,
        MODE_PROG  = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        DS_IDLE, DS_U1, DS_U2, DS_PWAIT, DS_SETUP,
        DS_SU1, DS_SU2, DS_BYP, DS_BPROG, DS_BEXIT
    } dec_state_e;

    typedef enum logic [1:0] {
        EN_IDLE, EN_PROG, EN_ZERO, EN_WIPE
    } eng_state_e;

    function automatic logic in_bypass(dec_state_e s);
        return (s == DS_BYP) || (s == DS_BPROG) || (s == DS_BEXIT);
    endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              go_prog,
    output logic              go_erase,
    output logic              bypass
);

    dec_state_e st, nxt;
    logic hit_a, hit_b, take;

    assign hit_a  = (wr_addr == ADDR_W'(UNLOCK_ADDR_A));
    assign hit_b  = (wr_addr == ADDR_W'(UNLOCK_ADDR_B));
    assign take   = wr_en && !busy;
    assign bypass = in_bypass(st);

    always_comb begin
        nxt      = st;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        if (take) begin
            if (!in_bypass(st) && wr_data == CODE_RESET) begin
                nxt = DS_IDLE;
            end else begin
                case (st)
                    DS_IDLE:  if (hit_a && wr_data == UNLOCK_D1) nxt = DS_U1;
                    DS_U1:    nxt = (hit_b && wr_data == UNLOCK_D2) ? DS_U2 : DS_IDLE;
                    DS_U2: begin
                        nxt = DS_IDLE;
                        if (hit_a && wr_data == CODE_PROG)   nxt = DS_PWAIT;
                        if (hit_a && wr_data == CODE_SETUP)  nxt = DS_SETUP;
                        if (hit_a && wr_data == CODE_BYPASS) nxt = DS_BYP;
                    end
                    DS_PWAIT: begin
                        go_prog = 1'b1;
                        nxt     = DS_IDLE;
                    end
                    DS_SETUP: nxt = (hit_a && wr_data == UNLOCK_D1) ? DS_SU1 : DS_IDLE;
                    DS_SU1:   nxt = (hit_b && wr_data == UNLOCK_D2) ? DS_SU2 : DS_IDLE;
                    DS_SU2: begin
                        nxt = DS_IDLE;
                        if (hit_a && wr_data == CODE_ERASE) go_erase = 1'b1;
                    end
                    DS_BYP: begin
                        if (wr_data == CODE_PROG)   nxt = DS_BPROG;
                        if (wr_data == CODE_BEXIT1) nxt = DS_BEXIT;
                    end
                    DS_BPROG: begin
                        go_prog = 1'b1;
                        nxt     = DS_BYP;
                    end
                    DS_BEXIT: nxt = (wr_data == CODE_BEXIT2) ? DS_IDLE : DS_BYP;
                    default:  nxt = DS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= DS_IDLE;
        else     st <= nxt;
    end

    // R6: stray data in bypass leaves the state untouched
    p_bypass_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (st == DS_BYP && wr_en && !busy && wr_data != CODE_PROG && wr_data != CODE_BEXIT1)
        |=> (st == DS_BYP));

    // R7: 90h then 00h always exits bypass
    p_bypass_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (st == DS_BEXIT && wr_en && !busy && wr_data == CODE_BEXIT2) |=> (st == DS_IDLE));

    // R10: the sequence state is frozen while the engine is busy
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(st));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int PROG_CYC = 4,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(PROG_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic [IDX_W-1:0] op_idx,
    input  logic [7:0]       op_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             busy,
    output mode_e            mode
);

    eng_state_e       est;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx, lat_idx;
    logic [7:0]       lat_data;
    logic [7:0]       mem [DEPTH];
    logic             last_idx, all_ff;

    assign last_idx = (idx == IDX_W'(DEPTH - 1));
    assign rd_data  = mem[rd_idx];
    assign busy     = (est != EN_IDLE);

    always_comb begin
        case (est)
            EN_PROG:          mode = MODE_PROG;
            EN_ZERO, EN_WIPE: mode = MODE_ERASE;
            default:          mode = MODE_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est      <= EN_IDLE;
            cnt      <= '0;
            idx      <= '0;
            lat_idx  <= '0;
            lat_data <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            case (est)
                EN_IDLE: begin
                    if (start_erase) begin
                        est <= EN_ZERO;
                        idx <= '0;
                    end else if (start_prog) begin
                        est      <= EN_PROG;
                        cnt      <= CNT_W'(PROG_CYC - 1);
                        lat_idx  <= op_idx;
                        lat_data <= op_data;
                    end
                end
                EN_PROG: begin
                    if (cnt == '0) begin
                        mem[lat_idx] <= mem[lat_idx] & lat_data;
                        est          <= EN_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                EN_ZERO: begin
                    mem[idx] <= 8'h00;
                    idx      <= last_idx ? '0 : idx + 1'b1;
                    if (last_idx) est <= EN_WIPE;
                end
                EN_WIPE: begin
                    mem[idx] <= 8'hFF;
                    idx      <= last_idx ? '0 : idx + 1'b1;
                    if (last_idx) est <= EN_IDLE;
                end
                default: est <= EN_IDLE;
            endcase
        end
    end

    always_comb begin
        all_ff = 1'b1;
        for (int i = 0; i < DEPTH; i++) all_ff = all_ff && (mem[i] == 8'hFF);
    end

    // R2: an accepted program command shows programming mode next cycle
    p_prog_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start_prog && !start_erase && !busy) |=> (busy && mode == MODE_PROG));

    // R3: an accepted erase command shows erase mode next cycle
    p_erase_start_r3: assert property (@(posedge clk) disable iff (rst)
        (start_erase && !busy) |=> (busy && mode == MODE_ERASE));

    // R3: a finished erase leaves every location at FFh
    p_erase_result_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(mode) == MODE_ERASE) |-> all_ff);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DEPTH    = 16,
    parameter int PROG_CYC = 4,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [1:0]        mode,
    output logic              bypass
);

    logic  go_prog, go_erase;
    mode_e eng_mode;

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .go_prog  (go_prog),
        .go_erase (go_erase),
        .bypass   (bypass)
    );

    flash_op_engine #(.DEPTH(DEPTH), .PROG_CYC(PROG_CYC)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .start_prog  (go_prog),
        .start_erase (go_erase),
        .op_idx      (wr_addr[IDX_W-1:0]),
        .op_data     (wr_data),
        .rd_idx      (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .mode        (eng_mode)
    );

    assign mode = eng_mode;

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

    localparam int ADDR_W   = 11;
    localparam int DEPTH    = 16;
    localparam int PROG_CYC = 4;
    localparam int IDX_W    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [IDX_W-1:0]  rd_addr;
    logic [7:0]        rd_data;
    logic              busy;
    logic [1:0]        mode;
    logic              bypass;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PROG_CYC(PROG_CYC)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .mode(mode), .bypass(bypass)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_errors = 0;
    int    n_cycles = 0;
    string tag = "R1";

    // behavioural reference: 0 idle,1 u1,2 u2,3 pwait,4 setup,5 su1,6 su2,7 byp,8 bprog,9 bexit
    int         ms = 0;
    int         m_busy = 0;
    int         m_mode = 0;
    int         m_pidx = 0;
    logic [7:0] m_pdat = 8'h00;
    logic [7:0] m_mem [DEPTH];
    int         rd_ptr = 0;

    function automatic bit m_byp();
        return ms == 7 || ms == 8 || ms == 9;
    endfunction

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(bit w, int a, int d);
        if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) begin
                if (m_mode == 2) m_mem[m_pidx] = m_mem[m_pidx] & m_pdat;
                else for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                m_mode = 0;
            end
        end else if (w) begin
            if (!m_byp() && d == 'hF0) ms = 0;
            else case (ms)
                0: if (a == 'h555 && d == 'hAA) ms = 1;
                1: ms = (a == 'h2AA && d == 'h55) ? 2 : 0;
                2: if (a == 'h555 && d == 'hA0) ms = 3;
                   else if (a == 'h555 && d == 'h80) ms = 4;
                   else if (a == 'h555 && d == 'h20) ms = 7;
                   else ms = 0;
                3, 8: begin
                    m_busy = PROG_CYC; m_mode = 2;
                    m_pidx = a % DEPTH; m_pdat = 8'(d);
                    ms = (ms == 8) ? 7 : 0;
                end
                4: ms = (a == 'h555 && d == 'hAA) ? 5 : 0;
                5: ms = (a == 'h2AA && d == 'h55) ? 6 : 0;
                6: begin
                    if (a == 'h555 && d == 'h10) begin m_busy = 2 * DEPTH; m_mode = 1; end
                    ms = 0;
                end
                7: if (d == 'hA0) ms = 8; else if (d == 'h90) ms = 9;
                9: ms = (d == 'h00) ? 0 : 7;
                default: ms = 0;
            endcase
        end
    endtask

    task automatic cyc(bit w, int a, int d);
        @(negedge clk);
        rd_addr = IDX_W'(rd_ptr);
        #1;
        check("busy", int'(busy), int'(m_busy > 0));
        check("mode", int'(mode), m_mode);
        check("bypass", int'(bypass), int'(m_byp()));
        if (m_busy == 0) check("rd_data", int'(rd_data), int'(m_mem[rd_ptr]));
        rd_ptr = (rd_ptr + 1) % DEPTH;
        wr_en   = w;
        wr_addr = ADDR_W'(a);
        wr_data = 8'(d);
        @(posedge clk);
        model_step(w, a, d);
    endtask

    task automatic wr(int a, int d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
    endtask

    task automatic unlock();
        wr('h555, 'hAA);
        wr('h2AA, 'h55);
    endtask

    task automatic settle();
        while (m_busy > 0) cyc(1'b0, 0, 0);
        idle(DEPTH);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 100000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        tag = "R1"; idle(DEPTH);

        // R2: normal program, then a second program clears more bits
        tag = "R2";
        unlock(); wr('h555, 'hA0); wr('h003, 'h5A); settle();
        unlock(); wr('h555, 'hA0); wr('h7F3, 'h0F); settle();

        // R10: a full program sequence issued while busy is dropped
        tag = "R10";
        unlock(); wr('h555, 'hA0); wr('h005, 'h33);
        unlock(); wr('h555, 'hA0); wr('h006, 'h00);
        settle();

        // R8: wrong address / wrong code break the sequence
        tag = "R8";
        wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr('h007, 'h00); settle();
        unlock(); wr('h555, 'h77); wr('h007, 'h00); settle();
        unlock(); wr('h555, 'h80); wr('h555, 'hAA); wr('h2AA, 'h54); wr('h555, 'h10); settle();

        // R9: F0h aborts a pending program, also in the data slot
        tag = "R9";
        unlock(); wr('h555, 'hA0); wr('h008, 'hF0); wr('h008, 'h00); settle();
        wr('h555, 'hAA); wr('h000, 'hF0); wr('h2AA, 'h55); settle();

        // R4: enter bypass
        tag = "R4";
        unlock(); wr('h555, 'h20); idle(2);

        // R6: stray writes in bypass are dropped
        tag = "R6";
        wr('h009, 'hF0); wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h10); wr('h00A, 'h00);
        idle(DEPTH);

        // R5: bypass program twice, staying in bypass
        tag = "R5";
        wr('h123, 'hA0); wr('h009, 'h00); settle();
        wr('h000, 'hA0); wr('h00C, 'hC3); settle();

        // R7: 90h then wrong data stays, 90h then 00h exits
        tag = "R7";
        wr('h3FF, 'h90); wr('h001, 'h11); idle(2);
        wr('h000, 'h90); wr('h7FF, 'h00); idle(2);
        wr('h00D, 'hA0); wr('h00D, 'h00); settle();

        // R3: six-cycle chip erase, with writes during it ignored
        tag = "R3";
        unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10);
        tag = "R10";
        wr('h555, 'hF0); unlock(); wr('h555, 'h20);
        tag = "R3";
        settle();

        finish_run();
    end

endmodule